// File: doc/BRIEF.md
# Periodic Interval Timer with Wait Mode

This block is an interval timer that software controls through a small register bus. Once enabled, an internal counter goes up by one on every clock, from zero to a programmable terminal count. On each terminal event the timer sets a sticky status flag. It then follows one of two policies. In continuous mode the counter wraps to zero in the same step and keeps counting. In wait mode the counter parks at zero until software releases it. Software releases it either by writing one to the status flag or by turning the enable off and on again.

A level interrupt goes to the CPU whenever the status flag is set and interrupts are enabled. Software can read the counter through a readback register. The value returned is captured when the read is accepted and holds until the response has completed, while the live counter keeps running.

Top module: `slice_timer`

## Requirements
- R1: While reset is asserted, and right after it, ready and interrupt are low and every register reads zero.
- R2: A request is accepted on a clock where valid is high and no response is pending. Ready is high for exactly the following cycle, and read data is valid with it.
- R3: At word 0 the control word holds continuous-mode in bit 26, interrupt-enable in bit 25 and timer-enable in bit 24, with all other bits reading zero. At word 1 the terminal count occupies the low CNT_W bits, with the upper bits reading zero.
- R4: While timer-enable is low, the counter is held at zero.
- R5: While enabled and not parked, the counter increases by one per clock. Word 2 shows it in the low CNT_W bits with the upper bits zero, and writes to word 2 have no effect.
- R6: In continuous mode, the counter returns to zero on the edge where it equals terminal count minus one. The period is therefore the terminal count in clocks.
- R7: In wait mode, the counter returns to zero on that same edge and then stays parked at zero.
- R8: Bit 0 of word 3 is the status flag. It is set on every terminal event in both modes and cleared by writing 1 to it. Writing 0 has no effect.
- R9: A parked counter resumes from zero after a status clear or after timer-enable goes low and then high.
- R10: A terminal count of zero behaves like one, so a terminal event occurs on every enabled clock.
- R11: When a status clear and a terminal event fall on the same clock, the flag stays set.
- R12: The interrupt is high exactly when the status flag and interrupt-enable are both set. Interrupt-enable has no influence on counting or on the flag.
- R13: A counter read returns the value held at the edge of acceptance. The read data does not change until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid, held until ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2 | Word index: 0 control, 1 terminal count, 2 counter, 3 status |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata_o | output | DATA_W | Read data, valid with ready |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
The bench builds the timer with an 8-bit counter, so the largest terminal count of 255 and the full-width wrap take only a few hundred clocks. For each terminal count in a sweep that includes 0, 1 and 255, it runs both modes and reads at staggered gaps. It compares every count and status read against arithmetic from the enable, clear and disable edges. The 8-bit width also lets it check that unused upper bits read as zero. A terminal count of 1 puts an event on every clock, which forces the clear-versus-event collision.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int SEL_W        = 2;
  localparam int CTRL_RUN_BIT = 26;
  localparam int CTRL_IE_BIT  = 25;
  localparam int CTRL_EN_BIT  = 24;
  localparam int STAT_BIT     = 0;

  typedef enum logic [SEL_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_TERM  = 2'd1,
    REG_COUNT = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic run;
    logic irq_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/slt_core.sv
module slt_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] term_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             halted_o,
  output logic             status_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, last;
  logic             halted_q, status_q, evt;

  // zero terminal count behaves as one
  assign last = (term_i == '0) ? '0 : term_i - ONE;
  assign evt  = en_i & ~halted_q & (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      halted_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q    <= '0;
      halted_q <= 1'b0;
    end else if (evt) begin
      cnt_q    <= '0;
      halted_q <= ~run_i;
    end else if (halted_q) begin
      if (clr_i) halted_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= 1'b0;
    else if (evt)   status_q <= 1'b1;
    else if (clr_i) status_q <= 1'b0;
  end

  assign cnt_o    = cnt_q;
  assign halted_o = halted_q;
  assign status_o = status_q;
endmodule

// File: rtl/slt_regs.sv
module slt_regs
  import slt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [SEL_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              status_i,
  output logic              en_o,
  output logic              run_o,
  output logic              irq_en_o,
  output logic [CNT_W-1:0]  term_o,
  output logic              clr_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic              pending_q, accept, unused_wdata;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  term_q;
  logic [DATA_W-1:0] rdata_q, rd_mux, cnt_word, term_word;
  reg_sel_e          sel;

  assign accept       = req_valid_i & ~pending_q;
  assign sel          = reg_sel_e'(req_addr_i);
  assign unused_wdata = ^req_wdata_i;

  generate
    if (PAD_W > 0) begin : g_pad
      assign cnt_word  = {{PAD_W{1'b0}}, cnt_i};
      assign term_word = {{PAD_W{1'b0}}, term_q};
    end else begin : g_nopad
      assign cnt_word  = cnt_i;
      assign term_word = term_q;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_CTRL: begin
        rd_mux[CTRL_RUN_BIT] = ctrl_q.run;
        rd_mux[CTRL_IE_BIT]  = ctrl_q.irq_en;
        rd_mux[CTRL_EN_BIT]  = ctrl_q.en;
      end
      REG_TERM:  rd_mux = term_word;
      REG_COUNT: rd_mux = cnt_word;
      REG_STAT:  rd_mux[STAT_BIT] = status_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      rdata_q   <= '0;
      ctrl_q    <= '0;
      term_q    <= '0;
    end else begin
      pending_q <= accept;
      // snapshot taken at acceptance, held through the response
      if (accept) rdata_q <= req_write_i ? '0 : rd_mux;
      if (accept && req_write_i) begin
        case (sel)
          REG_CTRL: ctrl_q <= '{run:    req_wdata_i[CTRL_RUN_BIT],
                                irq_en: req_wdata_i[CTRL_IE_BIT],
                                en:     req_wdata_i[CTRL_EN_BIT]};
          REG_TERM: term_q <= req_wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign clr_o       = accept & req_write_i & (sel == REG_STAT) & req_wdata_i[STAT_BIT];
  assign req_ready_o = pending_q;
  assign rsp_rdata_o = rdata_q;
  assign en_o        = ctrl_q.en;
  assign run_o       = ctrl_q.run;
  assign irq_en_o    = ctrl_q.irq_en;
  assign term_o      = term_q;
endmodule

// File: rtl/slice_timer.sv
module slice_timer
  import slt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [SEL_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  logic             en_w, run_w, irq_en_w, clr_w, halted_w, status_w;
  logic [CNT_W-1:0] cnt_w, term_w;

  slt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .rsp_rdata_o (rsp_rdata_o),
    .cnt_i       (cnt_w),
    .status_i    (status_w),
    .en_o        (en_w),
    .run_o       (run_w),
    .irq_en_o    (irq_en_w),
    .term_o      (term_w),
    .clr_o       (clr_w)
  );

  slt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_w),
    .run_i    (run_w),
    .clr_i    (clr_w),
    .term_i   (term_w),
    .cnt_o    (cnt_w),
    .halted_o (halted_w),
    .status_o (status_w)
  );

  assign irq_o = status_w & irq_en_w;
endmodule

// File: rtl/slice_timer_chk.sv
module slice_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              irq_o,
  input logic              en_i,
  input logic              irq_en_i,
  input logic              clr_i,
  input logic              halted_i,
  input logic              status_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  term_i
);
  logic [CNT_W-1:0] top_val;
  logic             at_top;
  assign top_val = (term_i == '0) ? '0 : term_i - CNT_W'(1);
  assign at_top  = en_i && !halted_i && (cnt_i == top_val);

  // R2
  ready_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> req_ready_o);
  // R2
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);
  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0));
  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !halted_i && !at_top) |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));
  // R7
  park_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && halted_i && !clr_i) |=> $stable(cnt_i));
  // R11
  event_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_top |=> status_i);
  // R12
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
  // R12
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_i);
  // R13
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> $stable(rsp_rdata_o));
endmodule

bind slice_timer slice_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_rdata_o (rsp_rdata_o),
  .irq_o       (irq_o),
  .en_i        (en_w),
  .irq_en_i    (irq_en_w),
  .clr_i       (clr_w),
  .halted_i    (halted_w),
  .status_i    (status_w),
  .cnt_i       (cnt_w),
  .term_i      (term_w)
);

// File: tb/slice_timer_tb.sv
module slice_timer_tb;
  localparam int CLK_NS = 10;
  localparam int CW     = 8;
  localparam int DW     = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, write = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, irq;
  logic [DW-1:0] rdata;

  int cyc = 0, checks = 0, fails = 0;
  // reference model state
  int R = 0, C = 0, tce = 1;
  bit en_m = 0, run_m = 0, ie_m = 0, sticky = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slice_timer #(.CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(ready),
    .rsp_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  function automatic int ev_last(int n);
    if (!en_m || n - R < tce) return -1;
    if (run_m) return R + ((n - R) / tce) * tce;
    return R + tce;
  endfunction

  function automatic bit st_exp(int n);
    int e = ev_last(n);
    return sticky || (e >= 0 && e >= C);
  endfunction

  function automatic int cnt_exp(int n);
    int k = n - R;
    if (!en_m) return 0;
    if (run_m) return k % tce;
    return (k < tce) ? k : 0;
  endfunction

  task automatic bus(input bit wr, input int idx, input logic [31:0] wd,
                     output logic [31:0] rd, output int acc);
    @(negedge clk);
    chk(ready == 1'b0, "R2", ready, 0);
    valid = 1'b1; write = wr; addr = idx[1:0]; wdata = wd;
    acc = cyc + 1;
    @(negedge clk);
    chk(ready == 1'b1, "R2", ready, 1);
    rd = rdata;
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic wr_ctrl(input bit en, input bit run, input bit ie);
    logic [31:0] rd; int acc;
    bus(1, 0, {5'd0, run, ie, en, 24'd0}, rd, acc);
    if (en_m && !en) begin sticky = st_exp(acc); en_m = 0; end
    else if (!en_m && en) begin R = acc; en_m = 1; end
    run_m = run; ie_m = ie;
  endtask

  task automatic wr_stat(input bit v);
    logic [31:0] rd; int acc;
    bus(1, 3, {31'd0, v}, rd, acc);
    if (v) begin
      C = acc; sticky = 0;
      if (!run_m && en_m) R = acc;
    end
  endtask

  task automatic wr_term(input logic [31:0] t);
    logic [31:0] rd; int acc;
    bus(1, 1, t, rd, acc);
    tce = (t[CW-1:0] == 0) ? 1 : int'(t[CW-1:0]);
  endtask

  task automatic rd_cnt(input string req);
    logic [31:0] rd; int acc, e;
    bus(0, 2, '0, rd, acc);
    e = cnt_exp(acc - 1);
    chk(rd == e, req, rd, e);
    @(negedge clk);
    chk(rdata == rd, "R13", rdata, rd);
  endtask

  task automatic rd_stat(input string req);
    logic [31:0] rd; int acc; bit e, ei;
    bus(0, 3, '0, rd, acc);
    e = st_exp(acc - 1);
    chk(rd == {31'd0, e}, req, rd, e);
    ei = st_exp(acc) & ie_m;
    chk(irq == ei, "R12", irq, ei);
  endtask

  task automatic run_reads(input int span, input string req);
    int stop = cyc + span;
    int g = 0;
    while (cyc < stop) begin
      rd_cnt(req);
      rd_stat(req);
      repeat (g) @(negedge clk);
      g = (g + 1) % 3;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int acc;
    int tcs[6] = '{0, 1, 2, 3, 5, 255};

    // R1 during reset
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1", ready, 0);
    chk(irq == 1'b0, "R1", irq, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      bus(0, i, '0, rd, acc);
      chk(rd == 0, "R1", rd, 0);
    end

    // R3 field placement and reserved bits
    wr_term(32'hFFFF_FFFF);
    bus(0, 1, '0, rd, acc);
    chk(rd == 32'h0000_00FF, "R3", rd, 32'hFF);
    bus(1, 0, 32'hFFFF_FFFF, rd, acc);
    R = acc; en_m = 1; run_m = 1; ie_m = 1;
    bus(0, 0, '0, rd, acc);
    chk(rd == 32'h0700_0000, "R3", rd, 32'h0700_0000);
    rd_cnt("R5");
    rd_stat("R8");

    for (int s = 0; s < 6; s++) begin
      for (int m = 1; m >= 0; m--) begin
        string lbl;
        bit ie = bit'(s % 2);
        wr_ctrl(0, bit'(m), ie);
        wr_stat(1);
        rd_cnt("R4");
        wr_term(tcs[s]);
        bus(0, 1, '0, rd, acc);
        chk(rd == tcs[s], "R3", rd, tcs[s]);
        wr_ctrl(1, bit'(m), ie);
        lbl = (tcs[s] == 0) ? "R10" : (m ? "R6" : "R7");
        run_reads(2 * tce + 8, lbl);
        if (m) begin
          wr_stat(0);
          rd_stat("R8");
          bus(1, 2, 32'hFFFF_FFFF, rd, acc);
          rd_cnt("R5");
          wr_stat(1);
          rd_stat(tce == 1 ? "R11" : "R8");
          run_reads(tce + 6, "R6");
        end else begin
          wr_stat(0);
          rd_stat("R8");
          rd_cnt("R7");
          wr_stat(1);
          run_reads(2 * tce + 8, "R9");
          wr_ctrl(0, 1'b0, ie);
          rd_cnt("R4");
          wr_ctrl(1, 1'b0, ie);
          run_reads(tce + 6, "R9");
        end
      end
    end

    summary();
    $finish;
  end
endmodule